// File: doc/BRIEF.md
# Multiplexed Display Digit Scan Timer

This block produces the time-multiplexed drive timing for a scanned fluorescent-style display. Every scan frame is made of one slot for each enabled digit, followed by one key-scan slot. While a digit slot runs, exactly one digit strobe is high and a segment-enable window opens. Both are blanked for a programmable cut interval at the start and at the end of the slot, and this sets the display brightness. A digit index output names the digit that owns the current slot for the whole slot, so that outside logic can fetch that digit's segment pattern before the window opens.

The controller is a four-state machine. STOP is the idle state with the display disabled. BLANK is the first slot after enabling, forced dark. DIGIT scans one digit per slot. KEYSCAN is the slot after the last digit. The transitions are:
- STOP→BLANK when the display enable is high.
- BLANK→DIGIT at the end of the slot.
- DIGIT→DIGIT at the end of a slot when more digits remain.
- DIGIT→KEYSCAN at the end of the last digit's slot.
- KEYSCAN→DIGIT at the end of the slot, which starts a new frame.
- From any state to STOP when the enable goes low.

Top module: `digit_scan_timer`

## Requirements
- R1: Each slot lasts SLOT_SHORT (default 1024) clock cycles when `long_cycle` is 0 and SLOT_LONG (default 2048) cycles when it is 1. The internal slot count runs from 0 to length-1.
- R2: `digit_count` holds the number of digits minus one. The value 0 is treated as 1, so that at least 2 digits are scanned. Within a frame the digits are served in ascending order from 0 to that value, and bit i of `digit_strobe` is digit i. At most one strobe bit is high at any time.
- R3: `cut_code` c sets the cut to (c+1)·L/16 clocks at each end of the slot, where L is the slot length. The cut is limited to L/2-1. A strobe is high only for slot counts from cut up to, but not including, L-cut.
- R4: `seg_enable` is high exactly when a digit strobe is high.
- R5: After the last digit slot of each frame comes one key-scan slot of length L. `key_scan` is high for that whole slot, and no strobe or segment enable is active during it.
- R6: The first slot after leaving STOP (BLANK) keeps all strobes, `seg_enable` and `key_scan` at 0, and `digit_index` reads 0.
- R7: `cut_code` is sampled at the start of every slot. A change therefore takes effect at the next slot boundary without stopping the scan.
- R8: `digit_count` and `long_cycle` are sampled only at a frame start, which is either leaving STOP or the end of the key-scan slot.
- R9: During reset, and in the cycle after `disp_en` is seen low, all outputs are 0 and the slot counter is returned to 0. Enabling again restarts with a BLANK slot.
- R10: `digit_index` equals the serving digit for the whole of a DIGIT slot and is 0 in the BLANK and KEYSCAN slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_en | input | 1 | Display enable |
| digit_count | input | $clog2(MAX_DIGITS) | Number of digits minus one |
| long_cycle | input | 1 | Selects the long slot length |
| cut_code | input | 3 | Cut-width code |
| digit_strobe | output | MAX_DIGITS | One-hot digit strobes |
| seg_enable | output | 1 | Segment drive window |
| digit_index | output | $clog2(MAX_DIGITS) | Digit served by the current slot |
| key_scan | output | 1 | Key-scan slot flag |

## Verification
The bench uses short slots (32 and 64 cycles) so that a full sweep fits in the run. It runs every cut code with both slot lengths and with digit counts of 2, 3 and 16, plus the zero field. Comparing every cycle against an arithmetic timeline separates the window edges, the order of the digits, the placement of the key slot and the blank start slot. A long run that changes the cut code mid-slot and changes the digit count and length mid-frame shows whether sampling happens at slot boundaries or at frame boundaries. A disable pulse in the middle of that run, followed by reset checks, exercises the return to STOP and the blank restart.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_BLANK   = 2'd1,
        ST_DIGIT   = 2'd2,
        ST_KEYSCAN = 2'd3
    } scan_state_e;
endpackage

// File: rtl/dsc_slot_timer.sv
module dsc_slot_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] last_cnt,
    output logic [CW-1:0] cnt,
    output logic          slot_end
);
    assign slot_end = run && (cnt == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || slot_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R1: the slot count never passes the slot's last index
    p_cnt_in_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt);

    // R9: a stopped timer sits at zero
    p_cnt_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/dsc_cut_calc.sv
module dsc_cut_calc #(
    parameter int SLOT_SHORT = 1024,
    parameter int SLOT_LONG  = 2048,
    parameter int CW         = 11
) (
    input  logic [2:0]    code,
    input  logic          long_sel,
    output logic [CW-1:0] cut
);
    localparam logic [CW:0] LEN_S = (CW+1)'(SLOT_SHORT);
    localparam logic [CW:0] LEN_L = (CW+1)'(SLOT_LONG);

    logic [CW:0] len;
    logic [CW:0] unit;
    logic [CW:0] raw;
    logic [CW:0] cap;

    generate
        if (SLOT_SHORT == SLOT_LONG) begin : g_one_len
            assign len = LEN_S;
        end else begin : g_two_len
            assign len = long_sel ? LEN_L : LEN_S;
        end
    endgenerate

    always_comb begin
        unit = len >> 4;
        raw  = (CW+1)'({1'b0, code} + 4'd1) * unit;
        cap  = (len >> 1) - (CW+1)'(1);
        cut  = (raw > cap) ? cap[CW-1:0] : raw[CW-1:0];
    end
endmodule

// File: rtl/dsc_scan_fsm.sv
module dsc_scan_fsm
    import dsc_pkg::*;
#(
    parameter int SLOT_SHORT = 1024,
    parameter int SLOT_LONG  = 2048,
    parameter int MAX_DIGITS = 16,
    parameter int CW         = 11,
    parameter int IW         = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [IW-1:0]         digits_field,
    input  logic                  long_sel,
    input  logic [CW-1:0]         cnt,
    input  logic                  slot_end,
    input  logic [CW-1:0]         cut_next,
    output logic                  cut_len_sel,
    output logic                  run,
    output logic [CW-1:0]         last_cnt,
    output logic [MAX_DIGITS-1:0] dig_strobe,
    output logic                  seg_en,
    output logic [IW-1:0]         dig_idx,
    output logic                  key_flag
);
    localparam logic [IW-1:0] DMAX   = IW'(MAX_DIGITS - 1);
    localparam logic [CW-1:0] LAST_S = CW'(SLOT_SHORT - 1);
    localparam logic [CW-1:0] LAST_L = CW'(SLOT_LONG - 1);

    scan_state_e    state, state_nx;
    logic [IW-1:0]  digit_r, digit_nx;
    logic [IW-1:0]  n_r;
    logic [IW-1:0]  n_in;
    logic           long_r;
    logic [CW-1:0]  cut_r;
    logic           frame_start;
    logic           slot_start;
    logic           window;
    logic [CW:0]    end_sum;

    assign run         = (state != ST_STOP);
    assign last_cnt    = long_r ? LAST_L : LAST_S;
    assign frame_start = en && ((state == ST_STOP) ||
                                (state == ST_KEYSCAN && slot_end));
    assign slot_start  = frame_start || (en && slot_end);
    assign cut_len_sel = frame_start ? long_sel : long_r;
    assign n_in        = (digits_field == '0)  ? IW'(1) :
                         (digits_field > DMAX) ? DMAX   : digits_field;

    // next-state and digit sequencing
    always_comb begin
        state_nx = state;
        digit_nx = digit_r;
        unique case (state)
            ST_STOP: begin
                state_nx = ST_BLANK;
                digit_nx = '0;
            end
            ST_BLANK: begin
                if (slot_end) begin
                    state_nx = ST_DIGIT;
                    digit_nx = '0;
                end
            end
            ST_DIGIT: begin
                if (slot_end) begin
                    if (digit_r == n_r) begin
                        state_nx = ST_KEYSCAN;
                        digit_nx = '0;
                    end else begin
                        digit_nx = digit_r + IW'(1);
                    end
                end
            end
            ST_KEYSCAN: begin
                if (slot_end) begin
                    state_nx = ST_DIGIT;
                    digit_nx = '0;
                end
            end
        endcase
        if (!en) begin
            state_nx = ST_STOP;
            digit_nx = '0;
        end
    end

    // state register and sampled settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_STOP;
            digit_r <= '0;
            n_r     <= IW'(1);
            long_r  <= 1'b0;
            cut_r   <= '0;
        end else begin
            state   <= state_nx;
            digit_r <= digit_nx;
            if (frame_start) begin
                n_r    <= n_in;
                long_r <= long_sel;
            end
            if (slot_start) begin
                cut_r <= cut_next;
            end
        end
    end

    // output decode
    always_comb begin
        end_sum    = {1'b0, cnt} + {1'b0, cut_r};
        window     = (cnt >= cut_r) && (end_sum <= {1'b0, last_cnt});
        dig_strobe = '0;
        seg_en     = 1'b0;
        dig_idx    = '0;
        key_flag   = 1'b0;
        unique case (state)
            ST_STOP, ST_BLANK: begin
            end
            ST_DIGIT: begin
                dig_idx = digit_r;
                if (window) begin
                    dig_strobe = MAX_DIGITS'(1) << digit_r;
                    seg_en     = 1'b1;
                end
            end
            ST_KEYSCAN: begin
                key_flag = 1'b1;
            end
        endcase
    end

    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_strobe));

    p_digit_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        digit_r <= n_r);

    p_cut_capped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (({1'b0, cut_r} << 1) <= {1'b0, last_cnt}));

    p_seg_tracks_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_en == (dig_strobe != '0));

    p_key_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_flag |-> (dig_strobe == '0 && !seg_en));

    p_blank_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && en) |=> (dig_strobe == '0 && !key_flag && dig_idx == '0));

    p_cut_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slot_end) |=> $stable(cut_r));

    p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(state == ST_KEYSCAN && slot_end)) |=> ($stable(n_r) && $stable(long_r)));

    p_stop_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dig_strobe == '0 && !seg_en && !key_flag));
endmodule

// File: rtl/digit_scan_timer.sv
module digit_scan_timer #(
    parameter int SLOT_SHORT = 1024,
    parameter int SLOT_LONG  = 2048,
    parameter int MAX_DIGITS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          disp_en,
    input  logic [$clog2(MAX_DIGITS)-1:0] digit_count,
    input  logic                          long_cycle,
    input  logic [2:0]                    cut_code,
    output logic [MAX_DIGITS-1:0]         digit_strobe,
    output logic                          seg_enable,
    output logic [$clog2(MAX_DIGITS)-1:0] digit_index,
    output logic                          key_scan
);
    localparam int CW = $clog2(SLOT_LONG);
    localparam int IW = $clog2(MAX_DIGITS);

    logic [CW-1:0] cnt;
    logic          slot_end;
    logic          run;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] cut_next;
    logic          cut_len_sel;

    dsc_slot_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .last_cnt (last_cnt),
        .cnt      (cnt),
        .slot_end (slot_end)
    );

    dsc_cut_calc #(
        .SLOT_SHORT (SLOT_SHORT),
        .SLOT_LONG  (SLOT_LONG),
        .CW         (CW)
    ) u_cut (
        .code     (cut_code),
        .long_sel (cut_len_sel),
        .cut      (cut_next)
    );

    dsc_scan_fsm #(
        .SLOT_SHORT (SLOT_SHORT),
        .SLOT_LONG  (SLOT_LONG),
        .MAX_DIGITS (MAX_DIGITS),
        .CW         (CW),
        .IW         (IW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (disp_en),
        .digits_field (digit_count),
        .long_sel     (long_cycle),
        .cnt          (cnt),
        .slot_end     (slot_end),
        .cut_next     (cut_next),
        .cut_len_sel  (cut_len_sel),
        .run          (run),
        .last_cnt     (last_cnt),
        .dig_strobe   (digit_strobe),
        .seg_en       (seg_enable),
        .dig_idx      (digit_index),
        .key_flag     (key_scan)
    );
endmodule

// File: tb/digit_scan_timer_tb_top.sv
module digit_scan_timer_tb_top;
    localparam int SS = 32;
    localparam int SL = 64;
    localparam int MD = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disp_en;
    logic [3:0]    digit_count;
    logic          long_cycle;
    logic [2:0]    cut_code;
    logic [MD-1:0] digit_strobe;
    logic          seg_enable;
    logic [3:0]    digit_index;
    logic          key_scan;

    always #10 clk = ~clk;

    digit_scan_timer #(.SLOT_SHORT(SS), .SLOT_LONG(SL), .MAX_DIGITS(MD)) dut_i (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .digit_count(digit_count),
        .long_cycle(long_cycle), .cut_code(cut_code), .digit_strobe(digit_strobe),
        .seg_enable(seg_enable), .digit_index(digit_index), .key_scan(key_scan)
    );

    int checks = 0;
    int errors = 0;
    int bad_strobe = 0, bad_seg = 0, bad_key = 0, bad_idx = 0, bad_blank = 0, bad_stop = 0;

    // model: kind 0 stop, 1 blank, 2 digit, 3 key
    int m_kind = 0, m_cnt = 0, m_dig = 0, m_n = 1, m_L = SS, m_cut = 0;

    function automatic int cut_of(int code, int len);
        int r;
        r = (code + 1) * (len / 16);
        if (r > len / 2 - 1) r = len / 2 - 1;
        return r;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (!disp_en) begin
            m_kind = 0; m_cnt = 0; m_dig = 0;
        end else if (m_kind == 0) begin
            m_kind = 1; m_cnt = 0; m_dig = 0;
            m_n = (digit_count == 0) ? 1 : int'(digit_count);
            m_L = long_cycle ? SL : SS;
            m_cut = cut_of(int'(cut_code), m_L);
        end else if (m_cnt == m_L - 1) begin
            m_cnt = 0;
            if (m_kind == 1) begin
                m_kind = 2; m_dig = 0;
            end else if (m_kind == 2) begin
                if (m_dig == m_n) begin m_kind = 3; m_dig = 0; end
                else m_dig++;
            end else begin
                m_kind = 2; m_dig = 0;
                m_n = (digit_count == 0) ? 1 : int'(digit_count);
                m_L = long_cycle ? SL : SS;
            end
            m_cut = cut_of(int'(cut_code), m_L);
        end else begin
            m_cnt++;
        end
    endtask

    task automatic tick();
        logic [MD-1:0] e_str;
        bit act;
        model_step();
        @(posedge clk);
        @(negedge clk);
        act = (m_cnt >= m_cut) && (m_cnt < m_L - m_cut);
        e_str = (m_kind == 2 && act) ? (MD'(1) << m_dig) : '0;
        if (digit_strobe !== e_str) bad_strobe++;
        if (seg_enable !== (m_kind == 2 && act)) bad_seg++;
        if (key_scan !== (m_kind == 3)) bad_key++;
        if (int'(digit_index) != ((m_kind == 2) ? m_dig : 0)) bad_idx++;
        if (m_kind == 1 && (digit_strobe != 0 || seg_enable || key_scan || digit_index != 0)) bad_blank++;
        if (m_kind == 0 && (digit_strobe != 0 || seg_enable || key_scan || digit_index != 0)) bad_stop++;
    endtask

    task automatic close_run(string label);
        check(bad_strobe == 0, {"R2 R3 R1 strobe timing, ", label}, bad_strobe, 0);
        check(bad_seg == 0, {"R4 segment window, ", label}, bad_seg, 0);
        check(bad_key == 0, {"R5 key-scan slot, ", label}, bad_key, 0);
        check(bad_idx == 0, {"R10 digit index, ", label}, bad_idx, 0);
        check(bad_blank == 0, {"R6 blank first slot, ", label}, bad_blank, 0);
        check(bad_stop == 0, {"R9 stopped outputs, ", label}, bad_stop, 0);
        bad_strobe = 0; bad_seg = 0; bad_key = 0; bad_idx = 0; bad_blank = 0; bad_stop = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; disp_en = 1'b1; digit_count = 4'd3; long_cycle = 1'b0; cut_code = 3'd0;
        repeat (3) @(negedge clk);
        check(digit_strobe == 0 && !seg_enable && !key_scan && digit_index == 0,
              "R9 outputs during reset", int'(digit_strobe), 0);
        disp_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tick(); tick();
        check(digit_strobe == 0 && !key_scan, "R9 idle after reset", int'(key_scan), 0);

        // sweep: digit fields x slot length x cut code
        for (int f = 0; f < 4; f++) begin
            for (int lc = 0; lc < 2; lc++) begin
                for (int c = 0; c < 8; c++) begin
                    int nd;
                    int cyc;
                    nd = (f == 0) ? 1 : (f == 1) ? 2 : (f == 2) ? 15 : 0;
                    digit_count = 4'(nd);
                    long_cycle = lc[0];
                    cut_code = 3'(c);
                    disp_en = 1'b1;
                    cyc = (1 + 2 * (((nd == 0) ? 1 : nd) + 2)) * (lc ? SL : SS);
                    for (int i = 0; i < cyc; i++) tick();
                    disp_en = 1'b0;
                    tick(); tick();
                    close_run($sformatf("sweep n=%0d long=%0d cut=%0d", nd, lc, c));
                end
            end
        end

        // R7 R8: settings changed while scanning, with a disable pulse (R9)
        digit_count = 4'd3; long_cycle = 1'b0; cut_code = 3'd0; disp_en = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            tick();
            if (i % 37 == 5) cut_code = cut_code + 3'd3;
            if (i % 211 == 100) digit_count = digit_count + 4'd5;
            if (i % 500 == 250) long_cycle = ~long_cycle;
            if (i == 2345) disp_en = 1'b0;
            if (i == 2348) disp_en = 1'b1;
        end
        close_run("R7 R8 live setting changes and restart");

        disp_en = 1'b0;
        tick();
        check(digit_strobe == 0 && !seg_enable && !key_scan, "R9 stop after disable",
              int'(seg_enable), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule